// File: doc/BRIEF.md
# Field-Encoded Microcode Sequencer

This block is the control unit of a small datapath that runs a fixed three-step schedule. A step counter cycles through three addresses and reads a control store at each one. The store's word is a 9-bit control vector. Six of its lines are register load enables (t1, t2, y1, t3, t4, y2) and three are functional-unit multiplexer selects (add1, mult1, mult2). The datapath sits next to the block and takes this vector every clock.

The store can be built in two ways, chosen by a parameter. The flat variant keeps all nine bits per word. The encoded variant keeps seven bits per word and rebuilds the same nine lines with small decoders. It relies on the fact that some control lines are never active together. Lines that exclude one another share one binary field, and one code of each field means "none of these". Both variants drive identical vectors at every step, so the datapath cannot tell which one is fitted.

Top module: `ucs_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the step goes to 0. After reset, `step_o` is 0 and `ctrl_o` is 9'b110000000.
- R2: When `step_en` is high and `rst` is low at a rising edge, the step advances by one. The order is 0, 1, 2, then back to 0.
- R3: When `step_en` and `rst` are both low at an edge, `step_o` and `ctrl_o` keep their values.
- R4: `ctrl_o` bits 8 down to 0 are t1, t2, y1, t3, t4, y2, add1, mult1, mult2. The word at step 0 is 110000000, at step 1 it is 001110011 and at step 2 it is 000001100.
- R5: With `ENCODED`=1, each stored word has 7 bits. Bits [6:5] are the field for {t1, y1, y2} and bits [4:3] are the field for {t2, t3, add1}. In each of these fields, code 0 asserts no line, and codes 1, 2 and 3 assert the first, second and third member respectively. Bits 2, 1 and 0 drive t4, mult1 and mult2 directly, where 1 means the line is active. The stored words are 0101000 at step 0, 1010111 at step 1 and 1111000 at step 2.
- R6: For every step, the encoded variant drives the same `ctrl_o` as the flat variant (`ENCODED`=0).
- R7: If `rst` and `step_en` are high at the same edge, reset wins and the step becomes 0.
- R8: At most one line of {t1, y1, y2} is high at a time, and at most one line of {t2, t3, add1} is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance the schedule by one step at this edge |
| step_o | output | 2 | Current step, which is also the control store address |
| ctrl_o | output | 9 | Control vector for the datapath |

## Verification
Reset and step advance are the two functions that can fall on the same edge. The stimulus table raises both inputs together twice. One case starts at step 1, where an advance would give 2. The other starts at step 2, where an advance would wrap to 0. The expected result in both cases is step 0 with the step-0 word, so a design in which the advance wins shows a wrong step in the first case. A second instance, built with the flat store, runs next to the encoded one for hundreds of cycles. The two vectors are compared at every step, and each is also checked against a word that the bench decodes from its own copy of the encoded fields.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
  localparam int NUM_STEPS = 3;
  localparam int STEP_W    = $clog2(NUM_STEPS);
  localparam int CTRL_W    = 9;
  localparam int GRP_W     = 2;              // width of a shared field
  localparam int ENC_W     = 2 * GRP_W + 3;  // two shared fields + three single bits

  typedef logic [STEP_W-1:0] step_t;
  typedef logic [CTRL_W-1:0] ctrl_t;
  typedef logic [ENC_W-1:0]  enc_t;

  // Unencoded word: t1 t2 y1 t3 t4 y2 add1 mult1 mult2 (MSB..LSB)
  function automatic ctrl_t flat_word(input step_t s);
    case (s)
      step_t'(0): flat_word = 9'b110000000;
      step_t'(1): flat_word = 9'b001110011;
      step_t'(2): flat_word = 9'b000001100;
      default:    flat_word = '0;
    endcase
  endfunction

  // Encoded word: [6:5] {t1,y1,y2}, [4:3] {t2,t3,add1}, [2] t4, [1] mult1, [0] mult2
  function automatic enc_t enc_word(input step_t s);
    case (s)
      step_t'(0): enc_word = 7'b01_01_000;
      step_t'(1): enc_word = 7'b10_10_111;
      step_t'(2): enc_word = 7'b11_11_000;
      default:    enc_word = '0;
    endcase
  endfunction
endpackage

// File: rtl/ucs_step_counter.sv
module ucs_step_counter #(
  parameter int NUM_STEPS = 3,
  localparam int STEP_W = $clog2(NUM_STEPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  output logic [STEP_W-1:0] step,
  output logic              wrap_evt
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NUM_STEPS - 1);

  assign wrap_evt = step_en && (step == LAST);

  always_ff @(posedge clk) begin
    if (rst)           step <= '0;
    else if (wrap_evt) step <= '0;
    else if (step_en)  step <= step + 1'b1;
  end
endmodule

// File: rtl/ucs_field_decoder.sv
module ucs_field_decoder #(
  parameter int CODE_W = 2,
  localparam int LINES = (1 << CODE_W) - 1
) (
  input  logic [CODE_W-1:0] code,
  output logic [LINES-1:0]  lines
);
  // code 0 = none; code k asserts lines[k-1]
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign lines[i] = (code == CODE_W'(i + 1));
  end
endmodule

// File: rtl/ucs_store.sv
module ucs_store
  import ucs_pkg::*;
#(
  parameter bit ENCODED = 1'b1
) (
  input  step_t addr,
  output ctrl_t ctrl
);
  if (ENCODED) begin : g_enc
    enc_t             word;
    logic [2:0]       grp_a;   // t1, y1, y2
    logic [2:0]       grp_b;   // t2, t3, add1
    logic [0:0]       t4_l, m1_l, m2_l;

    assign word = enc_word(addr);

    ucs_field_decoder #(.CODE_W(GRP_W)) u_dec_a (.code(word[6:5]), .lines(grp_a));
    ucs_field_decoder #(.CODE_W(GRP_W)) u_dec_b (.code(word[4:3]), .lines(grp_b));
    ucs_field_decoder #(.CODE_W(1))     u_dec_t4 (.code(word[2]),  .lines(t4_l));
    ucs_field_decoder #(.CODE_W(1))     u_dec_m1 (.code(word[1]),  .lines(m1_l));
    ucs_field_decoder #(.CODE_W(1))     u_dec_m2 (.code(word[0]),  .lines(m2_l));

    assign ctrl = {grp_a[0], grp_b[0], grp_a[1], grp_b[1], t4_l[0],
                   grp_a[2], grp_b[2], m1_l[0], m2_l[0]};
  end else begin : g_flat
    assign ctrl = flat_word(addr);
  end
endmodule

// File: rtl/ucs_sequencer.sv
module ucs_sequencer
  import ucs_pkg::*;
#(
  parameter bit ENCODED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  output logic [STEP_W-1:0] step_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  step_t step;
  logic  wrap_evt;

  ucs_step_counter #(.NUM_STEPS(NUM_STEPS)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .step    (step),
    .wrap_evt(wrap_evt)
  );

  ucs_store #(.ENCODED(ENCODED)) u_store (
    .addr(step),
    .ctrl(ctrl_o)
  );

  assign step_o = step;
endmodule

// File: rtl/ucs_sequencer_chk.sv
module ucs_sequencer_chk
  import ucs_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              step_en,
  input logic              wrap_evt,
  input logic [STEP_W-1:0] step_o,
  input logic [CTRL_W-1:0] ctrl_o
);
  // R1 / R7: reset always lands on step 0, regardless of step_en
  p_reset_step_r1: assert property (@(posedge clk) rst |=> (step_o == '0));

  // R2: advance by one below the last step
  p_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (step_en && !wrap_evt) |=> (step_o == $past(step_o) + 1'b1));

  // R2: wrap event returns to step 0
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> (step_o == '0));

  // R3: hold when idle
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> ($stable(step_o) && $stable(ctrl_o)));

  // R8: shared-field groups are one-hot or zero
  p_group_a_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl_o[8], ctrl_o[6], ctrl_o[3]}));
  p_group_b_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl_o[7], ctrl_o[5], ctrl_o[2]}));

  // R6: whichever store is fitted, output equals the flat word
  p_flat_match_r6: assert property (@(posedge clk) disable iff (rst)
    ctrl_o == flat_word(step_o));
endmodule

bind ucs_sequencer ucs_sequencer_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .step_en (step_en),
  .wrap_evt(wrap_evt),
  .step_o  (step_o),
  .ctrl_o  (ctrl_o)
);

// File: tb/tb_ucs_sequencer.sv
module tb_ucs_sequencer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_en = 1'b0;
  logic [1:0] step_o, step_f;
  logic [8:0] ctrl_o, ctrl_f;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;   // 250 MHz

  ucs_sequencer #(.ENCODED(1'b1)) dut (
    .clk(clk), .rst(rst), .step_en(step_en), .step_o(step_o), .ctrl_o(ctrl_o));
  ucs_sequencer #(.ENCODED(1'b0)) dut_flat (
    .clk(clk), .rst(rst), .step_en(step_en), .step_o(step_f), .ctrl_o(ctrl_f));

  // R4 words, written per signal
  function automatic logic [8:0] exp_flat(input int s);
    logic t1, t2, y1, t3, t4, y2, add1, mult1, mult2;
    t1 = (s == 0); t2 = (s == 0);
    y1 = (s == 1); t3 = (s == 1); t4 = (s == 1); mult1 = (s == 1); mult2 = (s == 1);
    y2 = (s == 2); add1 = (s == 2);
    return {t1, t2, y1, t3, t4, y2, add1, mult1, mult2};
  endfunction

  // R5: bench copy of the encoded words and their decoding
  function automatic logic [8:0] exp_from_enc(input int s);
    logic [6:0] e;
    logic [1:0] a, b;
    e = (s == 0) ? 7'b0101000 : (s == 1) ? 7'b1010111 : 7'b1111000;
    a = e[6:5]; b = e[4:3];
    return {a == 2'd1, b == 2'd1, a == 2'd2, b == 2'd2, e[2],
            a == 2'd3, b == 2'd3, e[1], e[0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // {rst, step_en, expected step}
  localparam int NV = 15;
  localparam logic [3:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'd0}, {1'b0, 1'b1, 2'd1}, {1'b0, 1'b1, 2'd2}, {1'b0, 1'b1, 2'd0},
    {1'b0, 1'b0, 2'd0}, {1'b0, 1'b1, 2'd1}, {1'b0, 1'b0, 2'd1}, {1'b0, 1'b0, 2'd1},
    {1'b0, 1'b1, 2'd2}, {1'b0, 1'b0, 2'd2}, {1'b1, 1'b1, 2'd0}, {1'b0, 1'b1, 2'd1},
    {1'b1, 1'b1, 2'd0}, {1'b0, 1'b1, 2'd1}, {1'b0, 1'b1, 2'd2}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    string req;
    @(negedge clk); @(posedge clk); @(negedge clk);
    chk("R1 step", 32'(step_o), 0);
    chk("R1 ctrl", 32'(ctrl_o), 32'h180);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      rst = VEC[i][3]; step_en = VEC[i][2];
      req = (VEC[i][3] && VEC[i][2]) ? "R7" : VEC[i][3] ? "R1" : VEC[i][2] ? "R2" : "R3";
      @(posedge clk); @(negedge clk);
      chk(req, 32'(step_o), 32'(VEC[i][1:0]));
      chk("R4", 32'(ctrl_o), 32'(exp_flat(int'(VEC[i][1:0]))));
    end

    // R6 / R5 / R8 long run, flat and encoded side by side
    rst = 1'b1; step_en = 1'b0;
    @(posedge clk); @(negedge clk);
    rst = 1'b0; step_en = 1'b1;
    for (int n = 1; n <= 300; n++) begin
      @(posedge clk); @(negedge clk);
      chk("R2 run", 32'(step_o), n % 3);
      chk("R6", 32'(ctrl_o), 32'(ctrl_f));
      chk("R5", 32'(ctrl_o), 32'(exp_from_enc(n % 3)));
      chk("R8", 32'(($countones({ctrl_o[8], ctrl_o[6], ctrl_o[3]}) <= 1) &&
                    ($countones({ctrl_o[7], ctrl_o[5], ctrl_o[2]}) <= 1)), 1);
    end

    // R3 long hold at step 2 then R7 reset at wrap point
    while (step_o != 2'd2) begin @(posedge clk); @(negedge clk); end
    step_en = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R3 hold", 32'(ctrl_o), 32'h00C);
    rst = 1'b1; step_en = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R7 step", 32'(step_o), 0);
    chk("R7 ctrl", 32'(ctrl_o), 32'h180);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule